// File: doc/BRIEF.md
# Output Data and Data-Clock Phase Selector

This block sits at the digital output of a pixel pipeline. It runs on a clock at the sub-pixel slot rate and counts 48 slots per pixel period. It re-times the internal pixel word onto the output bus and generates an output data clock whose rising edge can be placed in any slot of the period. A small write port holds three settings: the launch phase, a clock mode, and an output delay of zero to three slot clocks. The delay separates the data clock's rising edge from the data transition. In the alternative clock mode, the data clock stops following the programmed phase. It then mirrors the inverted level of the incoming pixel clock, and the data launch keeps its programmed timing.

Each write goes first into a shadow copy. The working copy takes the shadow value at the pixel-period boundary, so a setting never changes part way through a period. After reset the counter starts at slot 0. The clock edge at which the counter holds value s is called slot s. Its effect can be seen on the outputs from the next cycle.

Top module: `dout_phase_sel`

## Requirements
- R1: While reset is held and right after it, `dout_o` and `dclk_o` are 0. The working settings are phase 0, delay step 2 and tracking mode, so the first data change comes at slot 2 and the first clock rise at slot 0.
- R2: In tracking mode, `dclk_o` goes high after slot P, where P is the working phase. It goes low after slot (P+24) mod 48, so it stays high for exactly 24 cycles.
- R3: `dout_o` takes the value `din_i` had at slot L = (P+D) mod 48, where D is the working delay. At every other slot it holds its value.
- R4: Writing k (0 to 3) to address 2 puts the data change exactly k slot clocks after the `dclk_o` rise. With k = 0 both change in the same cycle.
- R5: Writing 1 to bit 0 at address 1 selects fixed mode. In fixed mode `dclk_o` equals the inverse of `pix_clk_i` as sampled at the previous clock edge, and the data launch still follows R3. Writing 0 returns to tracking mode.
- R6: A write to address 0, 1 or 2 lands in a shadow register. It takes effect only at slot 47, and the new value first governs the period that starts with the following slot 0.
- R7: A phase write (address 0) of 48 or more is discarded, and the previous shadow phase is kept.
- R8: The launch slot wraps modulo 48. With phase 46 and delay 3, data changes at slot 1.
- R9: A write to address 3 changes no setting and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot-rate clock, 48 cycles per pixel period |
| rst_n | input | 1 | Asynchronous active-low reset |
| din_i | input | DATA_W | Internal pixel word to be re-timed |
| cfg_we_i | input | 1 | Setting write strobe |
| cfg_addr_i | input | 2 | Setting select: 0 phase, 1 mode, 2 delay, 3 unused |
| cfg_wdata_i | input | CNT_W | Write value |
| pix_clk_i | input | 1 | Level of the incoming pixel clock |
| dout_o | output | DATA_W | Re-timed output data bus |
| dclk_o | output | 1 | Output data clock |

## Verification
Two events can land in the same cycle. With delay 0, the data launch and the data-clock rise fall on the same slot. With phase 46 and a write made during the period, the slot-47 update of the working settings coincides with an active clock-high stretch, and a later launch wraps past slot 0. The bench sets each case up on purpose. It measures at the ports which slot each edge came from, and it compares every cycle against a behavioural model that applies shadow copies before it accepts the write of the same edge.

// File: rtl/dout_phase_pkg.sv
`timescale 1ns/1ps
package dout_phase_pkg;

   typedef enum logic [1:0] {
      CFG_PHASE = 2'd0,
      CFG_MODE  = 2'd1,
      CFG_DELAY = 2'd2,
      CFG_NONE  = 2'd3
   } cfg_addr_e;

   typedef enum logic {
      DCLK_TRACK = 1'b0,
      DCLK_FIXED = 1'b1
   } dclk_mode_e;

endpackage

// File: rtl/dout_phase_slot_ctr.sv
`timescale 1ns/1ps
module dout_phase_slot_ctr #(
   parameter int SLOTS = 48,
   localparam int CNT_W = $clog2(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] slot_o,
   output logic             last_o
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);

   logic [CNT_W-1:0] cnt_q;

   assign last_o = (cnt_q == LAST);
   assign slot_o = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (last_o)  cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/dout_phase_cfg.sv
`timescale 1ns/1ps
module dout_phase_cfg
   import dout_phase_pkg::*;
#(
   parameter int SLOTS     = 48,
   parameter int DLY_STEPS = 4,
   parameter int DLY_RST   = 2,
   localparam int CNT_W = $clog2(SLOTS),
   localparam int DLY_W = $clog2(DLY_STEPS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [1:0]       addr_i,
   input  logic [CNT_W-1:0] wdata_i,
   input  logic             period_end_i,
   output logic [CNT_W-1:0] phase_o,
   output logic [DLY_W-1:0] dly_o,
   output dclk_mode_e       mode_o
);

   logic [CNT_W-1:0] sh_phase_q;
   logic [DLY_W-1:0] sh_dly_q;
   dclk_mode_e       sh_mode_q;
   logic             phase_ok;
   cfg_addr_e        addr;

   assign addr     = cfg_addr_e'(addr_i);
   assign phase_ok = ({1'b0, wdata_i} < (CNT_W+1)'(SLOTS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_phase_q <= '0;
         sh_dly_q   <= DLY_W'(DLY_RST);
         sh_mode_q  <= DCLK_TRACK;
      end else if (we_i) begin
         unique case (addr)
            CFG_PHASE: if (phase_ok) sh_phase_q <= wdata_i;
            CFG_MODE:  sh_mode_q  <= dclk_mode_e'(wdata_i[0]);
            CFG_DELAY: sh_dly_q   <= wdata_i[DLY_W-1:0];
            default:   ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_o <= '0;
         dly_o   <= DLY_W'(DLY_RST);
         mode_o  <= DCLK_TRACK;
      end else if (period_end_i) begin
         phase_o <= sh_phase_q;
         dly_o   <= sh_dly_q;
         mode_o  <= sh_mode_q;
      end
   end

endmodule

// File: rtl/dout_phase_slot_add.sv
`timescale 1ns/1ps
module dout_phase_slot_add #(
   parameter int SLOTS = 48,
   localparam int CNT_W = $clog2(SLOTS),
   localparam bit IS_POW2 = ((SLOTS & (SLOTS - 1)) == 0)
) (
   input  logic [CNT_W-1:0] a_i,
   input  logic [CNT_W-1:0] b_i,
   output logic [CNT_W-1:0] sum_o
);

   logic [CNT_W:0] raw;
   assign raw = {1'b0, a_i} + {1'b0, b_i};

   generate
      if (IS_POW2) begin : g_mask
         assign sum_o = raw[CNT_W-1:0];
      end else begin : g_fold
         logic [CNT_W:0] folded;
         assign folded = raw - (CNT_W+1)'(SLOTS);
         assign sum_o  = (raw >= (CNT_W+1)'(SLOTS)) ? folded[CNT_W-1:0]
                                                     : raw[CNT_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/dout_phase_out_stage.sv
`timescale 1ns/1ps
module dout_phase_out_stage
   import dout_phase_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int SLOTS  = 48,
   localparam int CNT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  slot_i,
   input  logic [CNT_W-1:0]  launch_i,
   input  logic [CNT_W-1:0]  rise_i,
   input  logic [CNT_W-1:0]  fall_i,
   input  dclk_mode_e        mode_i,
   input  logic [DATA_W-1:0] din_i,
   input  logic              pix_clk_i,
   output logic [DATA_W-1:0] dout_o,
   output logic              dclk_o
);

   logic dclk_d;

   always_comb begin
      dclk_d = dclk_o;
      if (mode_i == DCLK_FIXED)  dclk_d = ~pix_clk_i;
      else if (slot_i == rise_i) dclk_d = 1'b1;
      else if (slot_i == fall_i) dclk_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_o <= '0;
         dclk_o <= 1'b0;
      end else begin
         if (slot_i == launch_i) dout_o <= din_i;
         dclk_o <= dclk_d;
      end
   end

endmodule

// File: rtl/dout_phase_sel.sv
`timescale 1ns/1ps
module dout_phase_sel
   import dout_phase_pkg::*;
#(
   parameter int DATA_W    = 12,
   parameter int SLOTS     = 48,
   parameter int DLY_STEPS = 4,
   parameter int DLY_RST   = 2,
   localparam int CNT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din_i,
   input  logic              cfg_we_i,
   input  logic [1:0]        cfg_addr_i,
   input  logic [CNT_W-1:0]  cfg_wdata_i,
   input  logic              pix_clk_i,
   output logic [DATA_W-1:0] dout_o,
   output logic              dclk_o
);

   localparam int DLY_W = $clog2(DLY_STEPS);
   localparam int HALF  = SLOTS / 2;

   generate
      if (SLOTS % 2 != 0 || SLOTS < 4) begin : g_bad_slots
         $error("SLOTS must be even and at least 4");
      end
      if ((DLY_STEPS & (DLY_STEPS - 1)) != 0 || DLY_STEPS < 2) begin : g_bad_steps
         $error("DLY_STEPS must be a power of two, at least 2");
      end
      if (DLY_STEPS > HALF) begin : g_bad_span
         $error("DLY_STEPS must not exceed half the period");
      end
      if (DLY_RST >= DLY_STEPS) begin : g_bad_rst
         $error("DLY_RST must be below DLY_STEPS");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] slot_cnt;
   logic             period_end;
   logic [CNT_W-1:0] act_phase;
   logic [DLY_W-1:0] act_dly;
   dclk_mode_e       act_mode;
   logic [CNT_W-1:0] launch_slot;
   logic [CNT_W-1:0] fall_slot;

   dout_phase_slot_ctr #(.SLOTS(SLOTS)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .slot_o (slot_cnt),
      .last_o (period_end)
   );

   dout_phase_cfg #(
      .SLOTS     (SLOTS),
      .DLY_STEPS (DLY_STEPS),
      .DLY_RST   (DLY_RST)
   ) u_cfg (
      .clk          (clk),
      .rst_n        (rst_n),
      .we_i         (cfg_we_i),
      .addr_i       (cfg_addr_i),
      .wdata_i      (cfg_wdata_i),
      .period_end_i (period_end),
      .phase_o      (act_phase),
      .dly_o        (act_dly),
      .mode_o       (act_mode)
   );

   dout_phase_slot_add #(.SLOTS(SLOTS)) u_launch_add (
      .a_i   (act_phase),
      .b_i   ({{(CNT_W-DLY_W){1'b0}}, act_dly}),
      .sum_o (launch_slot)
   );

   dout_phase_slot_add #(.SLOTS(SLOTS)) u_fall_add (
      .a_i   (act_phase),
      .b_i   (CNT_W'(HALF)),
      .sum_o (fall_slot)
   );

   dout_phase_out_stage #(
      .DATA_W (DATA_W),
      .SLOTS  (SLOTS)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_i    (slot_cnt),
      .launch_i  (launch_slot),
      .rise_i    (act_phase),
      .fall_i    (fall_slot),
      .mode_i    (act_mode),
      .din_i     (din_i),
      .pix_clk_i (pix_clk_i),
      .dout_o    (dout_o),
      .dclk_o    (dclk_o)
   );

endmodule

// File: rtl/dout_phase_sel_chk.sv
`timescale 1ns/1ps
module dout_phase_sel_chk #(
   parameter int DATA_W = 12,
   parameter int SLOTS  = 48,
   localparam int CNT_W = $clog2(SLOTS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CNT_W-1:0]  slot_cnt,
   input logic [CNT_W-1:0]  act_phase,
   input logic              act_mode,
   input logic [CNT_W-1:0]  launch_slot,
   input logic [CNT_W-1:0]  fall_slot,
   input logic [DATA_W-1:0] din_i,
   input logic              pix_clk_i,
   input logic [DATA_W-1:0] dout_o,
   input logic              dclk_o
);

   p_dclk_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_mode && slot_cnt == act_phase) |=> dclk_o);

   p_dclk_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_mode && slot_cnt == fall_slot) |=> !dclk_o);

   p_dout_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_cnt == launch_slot) |=> (dout_o == $past(din_i)));

   p_dout_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_cnt != launch_slot) |=> $stable(dout_o));

   p_fixed_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
      act_mode |=> (dclk_o == !$past(pix_clk_i)));

   p_apply_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_cnt != CNT_W'(SLOTS - 1)) |=> $stable(act_phase));

   p_phase_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, act_phase} < (CNT_W+1)'(SLOTS)));

endmodule

bind dout_phase_sel dout_phase_sel_chk #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .slot_cnt    (slot_cnt),
   .act_phase   (act_phase),
   .act_mode    (act_mode),
   .launch_slot (launch_slot),
   .fall_slot   (fall_slot),
   .din_i       (din_i),
   .pix_clk_i   (pix_clk_i),
   .dout_o      (dout_o),
   .dclk_o      (dclk_o)
);

// File: tb/dout_phase_sel_bench.sv
`timescale 1ns/1ps
module dout_phase_sel_bench;

   localparam int DW = 12;
   localparam int NS = 48;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] din_i = '0;
   logic          cfg_we_i = 1'b0;
   logic [1:0]    cfg_addr_i = '0;
   logic [5:0]    cfg_wdata_i = '0;
   logic          pix_clk_i = 1'b0;
   logic [DW-1:0] dout_o;
   logic          dclk_o;

   int    checks = 0;
   int    errors = 0;
   int    edges  = 0;
   bit    done   = 0;
   string stage  = "R1";

   always #4 clk = ~clk;

   dout_phase_sel u_dout_phase_sel (
      .clk(clk), .rst_n(rst_n), .din_i(din_i), .cfg_we_i(cfg_we_i),
      .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
      .pix_clk_i(pix_clk_i), .dout_o(dout_o), .dclk_o(dclk_o)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // behavioural reference model
   int m_cnt, m_ph, m_dly, m_mode, s_ph, s_dly, s_mode, m_dout, m_dclk;
   bit pix_at_edge;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_ph = 0; m_dly = 2; m_mode = 0;
         s_ph = 0; s_dly = 2; s_mode = 0; m_dout = 0; m_dclk = 0;
         edges = 0;
      end else begin
         pix_at_edge = pix_clk_i;
         edges++;
         if (m_cnt == (m_ph + m_dly) % NS) m_dout = int'(din_i);
         if (m_mode == 1) m_dclk = pix_clk_i ? 0 : 1;
         else if (m_cnt == m_ph) m_dclk = 1;
         else if (m_cnt == (m_ph + NS / 2) % NS) m_dclk = 0;
         if (m_cnt == NS - 1) begin
            m_cnt = 0; m_ph = s_ph; m_dly = s_dly; m_mode = s_mode;
         end else m_cnt++;
         if (cfg_we_i) begin
            case (cfg_addr_i)
               2'd0: if (int'(cfg_wdata_i) < NS) s_ph = int'(cfg_wdata_i);
               2'd1: s_mode = int'(cfg_wdata_i[0]);
               2'd2: s_dly = int'(cfg_wdata_i) % 4;
               default: ;
            endcase
         end
      end
   end

   // per-cycle comparison against the model
   initial forever begin
      @(negedge clk);
      if (rst_n && !done) begin
         chk({stage, " dout"}, int'(dout_o), m_dout);
         chk({stage, " dclk"}, int'(dclk_o), m_dclk);
      end
   end

   initial forever begin
      @(negedge clk);
      din_i = din_i + DW'(7);
   end

   int pix_n = 0;
   initial forever begin
      @(negedge clk);
      pix_n++;
      pix_clk_i = ((pix_n % 7) < 3);
   end

   task automatic wr(int a, int d);
      @(negedge clk);
      cfg_we_i = 1'b1; cfg_addr_i = 2'(a); cfg_wdata_i = 6'(d);
      @(negedge clk);
      cfg_we_i = 1'b0;
   endtask

   task automatic to_period();
      do @(negedge clk); while (edges % NS != 0);
   endtask

   task automatic meas(output int r, output int d);
      bit pc = dclk_o;
      logic [DW-1:0] pd = dout_o;
      r = -1; d = -1;
      for (int i = 0; i < 200 && (r < 0 || d < 0); i++) begin
         @(negedge clk);
         if (r < 0 && dclk_o && !pc) r = (edges - 1) % NS;
         if (d < 0 && dout_o != pd)  d = (edges - 1) % NS;
         pc = dclk_o; pd = dout_o;
      end
   endtask

   task automatic meas_rise(output int r);
      bit pc = dclk_o;
      r = -1;
      for (int i = 0; i < 200 && r < 0; i++) begin
         @(negedge clk);
         if (dclk_o && !pc) r = (edges - 1) % NS;
         pc = dclk_o;
      end
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int r, d, n;
      repeat (3) @(negedge clk);
      chk("R1 reset dout", int'(dout_o), 0);
      chk("R1 reset dclk", int'(dclk_o), 0);
      rst_n = 1'b1;
      meas(r, d);
      chk("R1 default rise slot", r, 0);
      chk("R1 default launch slot (delay 2)", d, 2);

      stage = "R4";
      wr(2, 0); wr(0, 10); to_period();
      meas(r, d);
      chk("R2 rise slot", r, 10);
      chk("R4 delay 0 launch slot", d, 10);
      n = 1;
      while (dclk_o && n < 100) begin @(negedge clk); if (dclk_o) n++; end
      chk("R2 high cycles", n, 24);

      stage = "R8";
      wr(2, 3); wr(0, 46); to_period();
      meas(r, d);
      chk("R8 rise slot", r, 46);
      chk("R8 wrapped launch slot", d, 1);
      chk("R4 delay 3 gap", (d - r + NS) % NS, 3);

      stage = "R7";
      wr(0, 50); wr(3, 5); to_period();
      meas(r, d);
      chk("R7 phase kept", r, 46);
      chk("R9 delay kept", d, 1);

      stage = "R6";
      to_period();
      while (edges % NS != 5) @(negedge clk);
      wr(0, 30);
      meas_rise(r);
      chk("R6 old phase in current period", r, 46);
      meas_rise(r);
      chk("R6 new phase next period", r, 30);

      stage = "R5";
      wr(1, 1); to_period();
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         chk("R5 fixed dclk", int'(dclk_o), pix_at_edge ? 0 : 1);
      end
      to_period();
      meas(r, d);
      chk("R5 launch slot in fixed mode", d, 33);

      stage = "R2";
      wr(1, 0); to_period();
      meas_rise(r);
      chk("R2 rise after return to tracking", r, 30);

      repeat (5) @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule